// File: doc/BRIEF.md
# Parallel ATA Host Strobe Timing Generator

This block turns single bus-access requests from a host port into correctly timed read and write strobes on a parallel ATA cable. Every access has an active phase, in which the read or write strobe is low, and a recovery phase, in which the strobe is high. Both phases are counted in core clocks. The two attached devices each get their own counts, and there are three classes of access, each with its own pair of counts: 8-bit command/control register accesses, 16-bit data-port PIO accesses and multiword DMA data cycles. The block decodes the access address to find the class and the chip selects. It extends the active phase while the device holds its ready line low, with a programmable timeout. One clock after recovery it pulses a completion flag.

A small configuration port holds the timing words, the ready timeout limit, the per-device Ultra DMA select bits, a sticky timeout flag and the device reset control. Each timing word packs the master device's count in its low byte and the slave device's count in its high byte. The device in use is chosen by the device bit of the most recent write to the device/head register. After reset every count is at its slowest value, so the first accesses are safe for any device.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, the six timing words (config indices 0 to 5) and the ready limit (index 8) read 0xFFFF, and the Ultra DMA select word (index 7), the control word (index 6) and the status word (index 9) read 0. Both strobes are high, `acc_busy` is low and `ata_reset_n` is high. An access made at these defaults holds its strobe low for 256 clocks and recovers for 256 clocks.
- R2: With a strobe count S and a recovery count R, the strobe is low for S+1 clocks and then high for R+1 clocks. `acc_done` is then high for exactly one clock. `ata_dior_n` is used for reads and `ata_diow_n` for writes.
- R3: Address 0x1F0 uses the PIO-data pair (strobe index 2, recovery index 3). Addresses 0x1F1 to 0x1F7 and 0x3F6 use the register pair (indices 0 and 1). A request with `acc_dma` high uses the DMA pair (indices 4 and 5), whatever its address.
- R4: Bit 4 of the data written to address 0x1F6 selects the device for later accesses: 0 selects the master, which uses bits 7:0 of each timing word, and 1 selects the slave, which uses bits 15:8. The write to 0x1F6 itself is timed for the device that was selected before it.
- R5: Addresses 0x1F0 to 0x1F7 drive `ata_cs0_n` low with `ata_da` equal to address bits 2:0. Address 0x3F6 drives `ata_cs1_n` low with `ata_da` = 6. DMA cycles keep both chip selects high with `ata_da` = 0. A non-DMA request at any other address is ignored: no strobe and no `acc_done`.
- R6: A read returns in `acc_rdata` the value of `ata_dd_in` sampled on the last strobe-low clock. A write drives `acc_wdata` onto `ata_dd_out`, with `ata_dd_oe` high, through the strobe and recovery phases.
- R7: While `ata_iordy` is low after the strobe count has run out, the strobe stays low. If the ready line stays low, the strobe ends after S+1+L clocks, where L is the ready limit (index 8), and status bit 0 (index 9) is set. This bit is sticky and is cleared by any write to index 9. If the ready line rises before that, the strobe ends on the clock that sees it high, and the flag is not set.
- R8: When bit 0 (master) or bit 1 (slave) of index 7 is set, a DMA request for that device is ignored. When the bit is clear, DMA requests for that device are timed with the DMA pair.
- R9: Bit 8 of the control word (index 6) drives the device reset. Writing 0x300 pulls `ata_reset_n` low and writing 0x200 releases it, from the clock after the write.
- R10: A request made while `acc_busy` is high is ignored and does not disturb the access in progress. `acc_busy` is high from the clock after acceptance through the `acc_done` clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for `cfg_addr` |
| acc_req | input | 1 | One-clock access request |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_dma | input | 1 | 1 = multiword DMA data cycle |
| acc_addr | input | 10 | Register offset of the access |
| acc_wdata | input | 16 | Write data |
| acc_busy | output | 1 | An access is in progress |
| acc_done | output | 1 | One-clock completion pulse |
| acc_rdata | output | 16 | Captured read data |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_cs0_n | output | 1 | Command block chip select, active low |
| ata_cs1_n | output | 1 | Control block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dd_out | output | 16 | Data bus output |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus input |
| ata_iordy | input | 1 | Device ready |
| ata_reset_n | output | 1 | Device reset, active low |

## Verification
Accesses are run at the default counts and then with timing words whose master and slave bytes, and whose strobe and recovery counts, are all different. Each measured strobe and recovery width therefore shows which class and which device were chosen. Each of the three classes is tried for both devices. Writes to the device/head register are included to show when the device choice takes effect. The ready line is tried held high, released partway through the extension, and held low until the limit runs out, to separate a normal extension from a timeout. Ignored requests are tried at an undecoded address, for a device with its Ultra DMA bit set, and while busy, and any strobe or completion pulse they cause is reported.

// File: rtl/ata_tmg_pkg.sv
package ata_tmg_pkg;
    localparam int CNT_W  = 8;
    localparam int REG_W  = 2 * CNT_W;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int TMO_W  = 16;
    localparam int CFG_AW = 4;
    localparam int NREG   = 9;

    // configuration word indices
    localparam int IX_TF_STB  = 0;
    localparam int IX_TF_RCV  = 1;
    localparam int IX_PIO_STB = 2;
    localparam int IX_PIO_RCV = 3;
    localparam int IX_DMA_STB = 4;
    localparam int IX_DMA_RCV = 5;
    localparam int IX_CTRL    = 6;
    localparam int IX_UDMA    = 7;
    localparam int IX_LIMIT   = 8;
    localparam int IX_STATUS  = 9;

    localparam int RST_BIT = 8;
    localparam int DEV_BIT = 4;

    localparam logic [ADDR_W-1:0] CMD_BASE = 10'h1F0;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 10'h3F6;
    localparam logic [ADDR_W-1:0] DEVHEAD  = 10'h1F6;

    typedef enum logic [1:0] {CL_TF, CL_PIO, CL_DMA} cls_e;
    typedef enum logic [1:0] {S_IDLE, S_STB, S_RCV, S_DONE} seq_e;

    typedef struct packed {
        logic [REG_W-1:0] stb;
        logic [REG_W-1:0] rcv;
    } pair_t;

    typedef struct packed {
        pair_t tf;
        pair_t pio;
        pair_t dma;
    } tmg_t;

    function automatic logic [REG_W-1:0] reg_rst_val(int idx);
        if (idx == IX_CTRL || idx == IX_UDMA) return '0;
        return '1;
    endfunction

    function automatic logic [CNT_W-1:0] dev_slice(logic [REG_W-1:0] w, logic dev);
        return dev ? w[REG_W-1:CNT_W] : w[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/ata_tmg_regs.sv
module ata_tmg_regs
    import ata_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              tmo_hit,
    output logic [REG_W-1:0]  cfg_rdata,
    output tmg_t              tmg,
    output logic [1:0]        udma_sel,
    output logic              dev_rst,
    output logic [TMO_W-1:0]  rdy_limit
);
    logic [REG_W-1:0] store [NREG];
    logic             tmo_flag;
    logic             clr_stat;

    assign clr_stat = cfg_we && (cfg_addr == CFG_AW'(IX_STATUS));

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                store[i] <= reg_rst_val(i);
            else if (cfg_we && cfg_addr == CFG_AW'(i))
                store[i] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           tmo_flag <= 1'b0;
        else if (tmo_hit)  tmo_flag <= 1'b1;
        else if (clr_stat) tmo_flag <= 1'b0;
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < NREG)          cfg_rdata = store[cfg_addr];
        else if (int'(cfg_addr) == IX_STATUS) cfg_rdata = {{(REG_W-1){1'b0}}, tmo_flag};
    end

    assign tmg.tf.stb  = store[IX_TF_STB];
    assign tmg.tf.rcv  = store[IX_TF_RCV];
    assign tmg.pio.stb = store[IX_PIO_STB];
    assign tmg.pio.rcv = store[IX_PIO_RCV];
    assign tmg.dma.stb = store[IX_DMA_STB];
    assign tmg.dma.rcv = store[IX_DMA_RCV];
    assign udma_sel    = store[IX_UDMA][1:0];
    assign dev_rst     = store[IX_CTRL][RST_BIT];
    assign rdy_limit   = TMO_W'(store[IX_LIMIT]);

    // R9: the reset output follows the control bit written one clock earlier
    p_reset_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(IX_CTRL)) |=> (dev_rst == $past(cfg_wdata[RST_BIT])));

    // R7: the timeout flag stays set until the status word is written
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !clr_stat) |=> tmo_flag);
endmodule

// File: rtl/ata_tmg_decode.sv
module ata_tmg_decode
    import ata_tmg_pkg::*;
(
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_dma,
    input  logic [1:0]        udma_sel,
    input  logic              dev,
    output logic              ok,
    output cls_e              cls,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da
);
    logic in_cmd, in_ctl;

    assign in_cmd = (acc_addr[ADDR_W-1:3] == CMD_BASE[ADDR_W-1:3]);
    assign in_ctl = (acc_addr == CTL_ADDR);

    always_comb begin
        ok    = 1'b0;
        cls   = CL_TF;
        cs0_n = 1'b1;
        cs1_n = 1'b1;
        da    = 3'd0;
        if (acc_dma) begin
            ok  = !udma_sel[dev];
            cls = CL_DMA;
        end else if (in_cmd) begin
            ok    = 1'b1;
            cls   = (acc_addr[2:0] == 3'd0) ? CL_PIO : CL_TF;
            cs0_n = 1'b0;
            da    = acc_addr[2:0];
        end else if (in_ctl) begin
            ok    = 1'b1;
            cs1_n = 1'b0;
            da    = acc_addr[2:0];
        end
    end
endmodule

// File: rtl/ata_tmg_seq.sv
module ata_tmg_seq
    import ata_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  stb_cnt,
    input  logic [CNT_W-1:0]  rcv_cnt,
    input  logic              cs0_n_in,
    input  logic              cs1_n_in,
    input  logic [2:0]        da_in,
    input  logic              iordy,
    input  logic [TMO_W-1:0]  limit,
    input  logic [DATA_W-1:0] dd_in,
    output logic              busy,
    output logic              done,
    output logic              dior_n,
    output logic              diow_n,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              tmo_hit
);
    seq_e             st;
    logic [CNT_W-1:0] cnt, rcv_q;
    logic [TMO_W-1:0] tmo;
    logic             wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            rcv_q  <= '0;
            tmo    <= '0;
            wr_q   <= 1'b0;
            cs0_n  <= 1'b1;
            cs1_n  <= 1'b1;
            da     <= 3'd0;
            dd_out <= '0;
            rdata  <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    st     <= S_STB;
                    cnt    <= stb_cnt;
                    rcv_q  <= rcv_cnt;
                    tmo    <= limit;
                    wr_q   <= write;
                    dd_out <= wdata;
                    cs0_n  <= cs0_n_in;
                    cs1_n  <= cs1_n_in;
                    da     <= da_in;
                end
                S_STB: begin
                    if (cnt != '0)
                        cnt <= cnt - 1'b1;
                    else if (!iordy && tmo != '0)
                        tmo <= tmo - 1'b1;
                    else begin
                        st  <= S_RCV;
                        cnt <= rcv_q;
                        if (!wr_q) rdata <= dd_in;
                    end
                end
                S_RCV: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           st  <= S_DONE;
                end
                S_DONE: begin
                    st    <= S_IDLE;
                    cs0_n <= 1'b1;
                    cs1_n <= 1'b1;
                    da    <= 3'd0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy    = (st != S_IDLE);
    assign done    = (st == S_DONE);
    assign dior_n  = !(st == S_STB && !wr_q);
    assign diow_n  = !(st == S_STB && wr_q);
    assign dd_oe   = wr_q && (st == S_STB || st == S_RCV);
    assign tmo_hit = (st == S_STB) && (cnt == '0) && !iordy && (tmo == '0);

    // R2: completion follows the recovery phase and lasts one clock
    p_done_after_rcv_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == S_RCV));
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: the strobe count steps down by one each clock
    p_stb_countdown_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_STB && $past(st) == S_STB && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
    // R7: a low ready line with time left keeps the strobe active
    p_rdy_extend_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_STB && cnt == '0 && !iordy && tmo != '0) |=> (st == S_STB));
    // R10: register address is held for the whole access
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(da));
    // R2: never both strobes at once
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({!dior_n, !diow_n}) <= 1);
endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ata_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic              acc_dma,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_busy,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_da,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in,
    input  logic              ata_iordy,
    output logic              ata_reset_n
);
    tmg_t             tmg;
    logic [1:0]       udma_sel;
    logic             dev_rst, tmo_hit, dev_q, dec_ok, start;
    logic [TMO_W-1:0] rdy_limit;
    cls_e             cls;
    logic             dec_cs0_n, dec_cs1_n;
    logic [2:0]       dec_da;
    pair_t            pair;

    ata_tmg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tmo_hit(tmo_hit), .cfg_rdata(cfg_rdata),
        .tmg(tmg), .udma_sel(udma_sel), .dev_rst(dev_rst), .rdy_limit(rdy_limit)
    );

    ata_tmg_decode u_dec (
        .acc_addr(acc_addr), .acc_dma(acc_dma), .udma_sel(udma_sel), .dev(dev_q),
        .ok(dec_ok), .cls(cls), .cs0_n(dec_cs0_n), .cs1_n(dec_cs1_n), .da(dec_da)
    );

    assign start = acc_req && !acc_busy && dec_ok;

    always_comb begin
        unique case (cls)
            CL_PIO:  pair = tmg.pio;
            CL_DMA:  pair = tmg.dma;
            default: pair = tmg.tf;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            dev_q <= 1'b0;
        else if (start && acc_write && !acc_dma && acc_addr == DEVHEAD)
            dev_q <= acc_wdata[DEV_BIT];
    end

    ata_tmg_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .write(acc_write), .wdata(acc_wdata),
        .stb_cnt(dev_slice(pair.stb, dev_q)), .rcv_cnt(dev_slice(pair.rcv, dev_q)),
        .cs0_n_in(dec_cs0_n), .cs1_n_in(dec_cs1_n), .da_in(dec_da),
        .iordy(ata_iordy), .limit(rdy_limit), .dd_in(ata_dd_in),
        .busy(acc_busy), .done(acc_done), .dior_n(ata_dior_n), .diow_n(ata_diow_n),
        .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n), .da(ata_da), .dd_out(ata_dd_out),
        .dd_oe(ata_dd_oe), .rdata(acc_rdata), .tmo_hit(tmo_hit)
    );

    assign ata_reset_n = !dev_rst;

    // R4: the device bit of an accepted device/head write is taken next clock
    p_dev_pick_r4: assert property (@(posedge clk) disable iff (rst)
        (start && acc_write && !acc_dma && acc_addr == DEVHEAD) |=> (dev_q == $past(acc_wdata[DEV_BIT])));
    // R10: a request during an access does not restart it
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_busy && !acc_done) |=> acc_busy);
endmodule

// File: tb/test_ata_strobe_timer.sv
module test_ata_strobe_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_req = 1'b0, acc_write = 1'b0, acc_dma = 1'b0;
    logic [9:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_busy, acc_done;
    logic [15:0] acc_rdata;
    logic        ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, ata_dd_oe, ata_reset_n;
    logic [2:0]  ata_da;
    logic [15:0] ata_dd_out;
    logic [15:0] ata_dd_in = '0;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ata_strobe_timer i_ata_strobe_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_write(acc_write), .acc_dma(acc_dma),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_busy(acc_busy), .acc_done(acc_done),
        .acc_rdata(acc_rdata), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da), .ata_dd_out(ata_dd_out),
        .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy),
        .ata_reset_n(ata_reset_n)
    );

    typedef struct {
        int          sw;
        int          rc;
        bit          wr;
        bit          cs0_n;
        bit          cs1_n;
        bit [2:0]    da;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: measures strobe and recovery widths and compares to the queue head
    bit   in_stb = 0, in_rec = 0, have = 0;
    int   sw = 0, rc = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit strobe = !ata_dior_n || !ata_diow_n;
            if (strobe) begin
                if (!in_stb) begin
                    in_stb = 1; sw = 0;
                    if (exp_q.size() == 0) begin
                        have = 0;
                        chk(0, "R5/R8/R10", "unexpected strobe", 1, 0);
                    end else begin
                        have = 1;
                        cur = exp_q[0];
                        chk(!ata_diow_n == cur.wr, cur.tag, "strobe kind", !ata_diow_n, cur.wr);
                        chk(ata_cs0_n == cur.cs0_n && ata_cs1_n == cur.cs1_n, {cur.tag, " R5"}, "chip selects",
                            {ata_cs0_n, ata_cs1_n}, {cur.cs0_n, cur.cs1_n});
                        chk(ata_da == cur.da, {cur.tag, " R5"}, "da", ata_da, cur.da);
                        if (cur.wr)
                            chk(ata_dd_oe && ata_dd_out == cur.data, {cur.tag, " R6"}, "write data",
                                ata_dd_out, cur.data);
                    end
                end
                sw++;
            end else if (in_stb) begin
                in_stb = 0; in_rec = 1; rc = 0;
            end
            if (in_rec && !strobe) begin
                if (acc_done) begin
                    in_rec = 0;
                    if (have) begin
                        chk(sw == cur.sw, {cur.tag, " R2"}, "strobe width", sw, cur.sw);
                        chk(rc == cur.rc, {cur.tag, " R2"}, "recovery width", rc, cur.rc);
                        if (!cur.wr)
                            chk(acc_rdata == cur.data, {cur.tag, " R6"}, "read data", acc_rdata, cur.data);
                        void'(exp_q.pop_front());
                    end
                end else rc++;
            end else if (acc_done && !in_rec) begin
                chk(0, "R2", "done without access", 1, 0);
            end
        end
    end

    task automatic cfg_wr(input int idx, input logic [15:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_addr = 4'(idx); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic cfg_chk(input int idx, input logic [15:0] expv, input string req);
        cfg_addr = 4'(idx);
        @(negedge clk);
        chk(cfg_rdata == expv, req, $sformatf("config word %0d", idx), cfg_rdata, expv);
    endtask

    task automatic access(input logic [9:0] addr, input bit dma, input bit wr,
                          input logic [15:0] data, input int esw, input int erc, input string tag);
        exp_t e;
        e.sw = esw; e.rc = erc; e.wr = wr; e.data = data; e.tag = tag;
        if (dma) begin e.cs0_n = 1; e.cs1_n = 1; e.da = 0; end
        else if (addr == 10'h3F6) begin e.cs0_n = 1; e.cs1_n = 0; e.da = 3'd6; end
        else begin e.cs0_n = 0; e.cs1_n = 1; e.da = addr[2:0]; end
        exp_q.push_back(e);
        if (!wr) ata_dd_in = data;
        @(posedge clk); #1;
        acc_req = 1; acc_addr = addr; acc_dma = dma; acc_write = wr; acc_wdata = data;
        @(posedge clk); #1;
        acc_req = 0;
        do @(negedge clk); while (!acc_done);
    endtask

    task automatic ignored(input logic [9:0] addr, input bit dma, input string tag);
        @(posedge clk); #1;
        acc_req = 1; acc_addr = addr; acc_dma = dma; acc_write = 0;
        @(posedge clk); #1;
        acc_req = 0;
        repeat (10) @(negedge clk);
        chk(!acc_busy && ata_dior_n && ata_diow_n, tag, "request not ignored", acc_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        for (int i = 0; i < 6; i++) cfg_chk(i, 16'hFFFF, "R1");
        cfg_chk(6, 16'h0000, "R1");
        cfg_chk(7, 16'h0000, "R1");
        cfg_chk(8, 16'hFFFF, "R1");
        cfg_chk(9, 16'h0000, "R1");
        chk(ata_dior_n && ata_diow_n && !acc_busy && ata_reset_n, "R1", "idle outputs",
            {ata_dior_n, ata_diow_n, acc_busy, ata_reset_n}, 4'b1101);
        access(10'h1F1, 0, 0, 16'h1234, 256, 256, "R1 default");

        // program distinct master/slave counts
        cfg_wr(0, 16'h0502); cfg_wr(1, 16'h0603);
        cfg_wr(2, 16'h0904); cfg_wr(3, 16'h0A01);
        cfg_wr(4, 16'h0706); cfg_wr(5, 16'h0802);
        cfg_chk(0, 16'h0502, "R2");

        // R3 classes, master
        access(10'h1F0, 0, 0, 16'hBEEF, 5, 2, "R3 pio master");
        access(10'h1F3, 0, 1, 16'h005A, 3, 4, "R3 tf write master");
        access(10'h3F6, 0, 0, 16'h00C3, 3, 4, "R5 ctl read");
        access(10'h1F1, 1, 0, 16'h4321, 7, 3, "R3 dma master");

        // R4 device select
        access(10'h1F6, 0, 1, 16'h0010, 3, 4, "R4 select slave");
        access(10'h1F0, 0, 0, 16'h7777, 10, 11, "R4 pio slave");
        access(10'h1F2, 0, 0, 16'h0011, 6, 7, "R4 tf slave");
        access(10'h000, 1, 1, 16'hA5A5, 8, 9, "R4 dma slave");
        access(10'h1F6, 0, 1, 16'h00A0, 6, 7, "R4 select master");
        access(10'h1F0, 0, 0, 16'h0F0F, 5, 2, "R4 pio master again");

        // R5 undecoded address
        ignored(10'h100, 0, "R5");

        // R8 Ultra DMA select
        cfg_wr(7, 16'h0001);
        ignored(10'h1F0, 1, "R8");
        cfg_wr(7, 16'h0002);
        access(10'h1F0, 1, 0, 16'h2468, 7, 3, "R8 dma allowed");

        // R10 request during busy
        fork
            access(10'h1F1, 0, 0, 16'h1357, 3, 4, "R10 ongoing");
            begin
                repeat (3) @(posedge clk); #1;
                acc_addr = 10'h1F2; acc_req = 1;
                @(negedge clk);
                chk(acc_busy, "R10", "busy during access", acc_busy, 1);
                @(posedge clk); #1 acc_req = 0;
            end
        join

        // R7 ready released early
        cfg_wr(8, 16'd100);
        ata_iordy = 0;
        fork
            access(10'h1F1, 0, 0, 16'h9999, 8, 4, "R7 iordy release");
            begin
                do @(negedge clk); while (ata_dior_n && ata_diow_n);
                repeat (7) @(negedge clk);
                ata_iordy = 1;
            end
        join
        cfg_chk(9, 16'h0000, "R7");

        // R7 timeout
        cfg_wr(8, 16'd3);
        ata_iordy = 0;
        access(10'h1F1, 0, 0, 16'h5555, 6, 4, "R7 timeout");
        ata_iordy = 1;
        cfg_chk(9, 16'h0001, "R7");
        access(10'h1F1, 0, 0, 16'h6666, 3, 4, "R7 after timeout");
        cfg_chk(9, 16'h0001, "R7");
        cfg_wr(9, 16'h0000);
        cfg_chk(9, 16'h0000, "R7");

        // R9 device reset
        cfg_wr(6, 16'h0300);
        @(negedge clk);
        chk(!ata_reset_n, "R9", "reset asserted", ata_reset_n, 0);
        cfg_wr(6, 16'h0200);
        @(negedge clk);
        chk(ata_reset_n, "R9", "reset released", ata_reset_n, 1);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending accesses", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule